// File: doc/BRIEF.md
# Phase Comparator with Lock Detector

This block compares two single-cycle tick streams, all in the oscillator clock domain: a divided reference tick and a divided feedback tick. Its core is a two-flop phase-frequency detector. The first tick of a comparison raises an "up" flag (reference first) or a "down" flag (feedback first). The second tick clears both flags at the next edge. Ticks that arrive in the same cycle leave both flags clear, so the detector never reports a zero error. The error span therefore runs from minus one period to plus one period of the compared signal.

The flags drive a pump command with three states: drive high, drive low, or float. Float is shown as a low output-enable. A polarity input chooses which error direction drives the pump high. The same flags drive two raw comparator outputs: a push-pull level and an open-drain pull-down request. The pump floats while the float-override input is low and while power-save is active. Power-save also holds the detector clear and forces the lock indication high. After power-save ends, the first tick of either kind is absorbed, so the loop restarts without an error burst.

A lock detector measures each error pulse in clock cycles. The lock flag drops in the cycle an error pulse reaches the unlock width. It rises again only after a run of consecutive comparisons whose width is within the lock width. One monitor output shows either the lock flag or a selected tick stream.

Top module: `phase_cmp_lock`

## Requirements
- R1: With `sense_pos`=1, a reference tick that precedes a feedback tick by d cycles gives `pump_oe`=1 and `pump_hi`=1 in the d samples that follow the reference tick's edge. The pump then floats (`pump_oe`=0, `pump_hi`=0).
- R2: With `sense_pos`=0, the pump level is reversed: reference-first error drives `pump_hi`=0, and feedback-first error drives `pump_hi`=1. The pulse lengths are the same as in R1.
- R3: A reference tick and a feedback tick in the same cycle leave `pump_oe`=0 and both comparator outputs low.
- R4: `cmp_ref_o` is 1 during feedback-first error when `sense_pos`=1, and during reference-first error when `sense_pos`=0. `cmp_fb_pull` is 1 during the opposite error direction.
- R5: With `mon_sel`=1, `mon_o` follows `ref_tick` in the same cycle when `sense_pos`=1, and follows `fb_tick` when `sense_pos`=0.
- R6: With `mon_sel`=0, `mon_o` shows the lock flag (1 = locked).
- R7: Once an error pulse has lasted `unlock_min` cycles, the lock flag reads 0 after that edge, even if the pulse has not ended.
- R8: The lock flag returns to 1 after LOCK_RUNS (3) consecutive comparisons whose width is at most `lock_max` cycles. A comparison whose width is above `lock_max` and below `unlock_min` restarts the run. A coincident comparison has width 0.
- R9: While `pump_allow`=0, `pump_oe`=0. The detector state is kept, and the pump drives again as soon as `pump_allow` returns to 1.
- R10: While `psave`=1, `pump_oe`=0, ticks are ignored, and the lock flag reads 1. The lock flag stays 1 after exit until an unlock event.
- R11: After `psave` falls, the first cycle carrying any tick sets no flag. Later ticks work normally.
- R12: After reset, `pump_oe`=0, both comparator outputs are 0, and the lock flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Divided reference tick, one cycle wide |
| fb_tick | input | 1 | Divided feedback tick, one cycle wide |
| sense_pos | input | 1 | Pump polarity select |
| pump_allow | input | 1 | 0 forces the pump to float |
| psave | input | 1 | Power-save request |
| mon_sel | input | 1 | 1 selects the tick monitor, 0 selects the lock flag |
| lock_max | input | CNT_W | Widest error (cycles) counted as in-lock |
| unlock_min | input | CNT_W | Error width (cycles) that declares unlock |
| pump_oe | output | 1 | Pump drive enable (0 = high impedance) |
| pump_hi | output | 1 | Pump drive level when enabled |
| cmp_ref_o | output | 1 | Push-pull comparator output |
| cmp_fb_pull | output | 1 | Open-drain comparator pull-down request |
| mon_o | output | 1 | Monitor output |

## Verification
A wrong detector flag shows on the pump and comparator outputs at the edge after the tick that caused it. Every lead and lag spacing up to several cycles is swept under both polarities, and each sample is compared with the pulse length computed from the spacing. A wrong width count or a wrong run count only shows on the lock flag. The bench tracks that flag with its own arithmetic model after every edge, so a miscount shows at the first edge where the design and the model differ. A missed restart after power-save shows as a pump pulse one edge after the first tick.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
   typedef struct packed {
      logic up;
      logic dn;
   } pd_flags_t;

   localparam int unsigned PCL_DEFAULT_RUNS = 3;
endpackage

// File: rtl/pcl_detector.sv
module pcl_detector
   import pcl_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ref_tick,
   input  logic      fb_tick,
   input  logic      psave,
   output pd_flags_t flags,
   output logic      cmp_done,
   output logic      restart_q
);
   pd_flags_t flags_q;
   logic      set_up, set_dn, both;

   always_comb begin
      set_up = flags_q.up | ref_tick;
      set_dn = flags_q.dn | fb_tick;
      both   = set_up & set_dn;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q   <= '0;
         restart_q <= 1'b0;
      end else if (psave) begin
         flags_q   <= '0;
         restart_q <= 1'b1;
      end else if (restart_q) begin
         flags_q <= '0;
         if (ref_tick || fb_tick) restart_q <= 1'b0;
      end else if (both) begin
         flags_q <= '0;
      end else begin
         flags_q.up <= set_up;
         flags_q.dn <= set_dn;
      end
   end

   assign flags    = flags_q;
   assign cmp_done = !psave && !restart_q && both;
endmodule

// File: rtl/pcl_lockdet.sv
module pcl_lockdet #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned RUNS  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             psave,
   input  logic             active,
   input  logic             cmp_done,
   input  logic [CNT_W-1:0] lock_max,
   input  logic [CNT_W-1:0] unlock_min,
   output logic             locked
);
   localparam int unsigned RUN_W = $clog2(RUNS + 1);

   logic [CNT_W-1:0] err_q, cur_w;
   logic             big_err, small_ok;

   always_comb begin
      if (!active)          cur_w = '0;
      else if (&err_q)      cur_w = err_q;
      else                  cur_w = err_q + 1'b1;
      big_err  = active && (cur_w >= unlock_min);
      small_ok = cmp_done && (cur_w <= lock_max);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   err_q <= '0;
      else if (psave)               err_q <= '0;
      else if (active && !cmp_done) err_q <= cur_w;
      else                          err_q <= '0;
   end

   generate
      if (RUNS == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        locked <= 1'b0;
            else if (psave)    locked <= 1'b1;
            else if (big_err)  locked <= 1'b0;
            else if (small_ok) locked <= 1'b1;
         end
      end else begin : g_run
         logic [RUN_W-1:0] good_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               locked <= 1'b0;
               good_q <= '0;
            end else if (psave) begin
               locked <= 1'b1;
               good_q <= '0;
            end else if (big_err) begin
               locked <= 1'b0;
               good_q <= '0;
            end else if (cmp_done) begin
               if (small_ok) begin
                  if (int'(good_q) + 1 >= int'(RUNS)) locked <= 1'b1;
                  if (int'(good_q) < int'(RUNS)) good_q <= good_q + 1'b1;
               end else begin
                  good_q <= '0;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pcl_outstage.sv
module pcl_outstage
   import pcl_pkg::*;
(
   input  pd_flags_t flags,
   input  logic      sense_pos,
   input  logic      pump_allow,
   input  logic      psave,
   input  logic      mon_sel,
   input  logic      ref_tick,
   input  logic      fb_tick,
   input  logic      locked,
   output logic      pump_oe,
   output logic      pump_hi,
   output logic      cmp_ref_o,
   output logic      cmp_fb_pull,
   output logic      mon_o
);
   always_comb begin
      pump_oe     = !psave && pump_allow && (flags.up || flags.dn);
      pump_hi     = sense_pos ? flags.up : flags.dn;
      cmp_ref_o   = sense_pos ? flags.dn : flags.up;
      cmp_fb_pull = sense_pos ? flags.up : flags.dn;
      if (mon_sel) mon_o = sense_pos ? ref_tick : fb_tick;
      else         mon_o = locked || psave;
   end
endmodule

// File: rtl/phase_cmp_lock.sv
module phase_cmp_lock
   import pcl_pkg::*;
#(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned LOCK_RUNS = PCL_DEFAULT_RUNS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   input  logic             fb_tick,
   input  logic             sense_pos,
   input  logic             pump_allow,
   input  logic             psave,
   input  logic             mon_sel,
   input  logic [CNT_W-1:0] lock_max,
   input  logic [CNT_W-1:0] unlock_min,
   output logic             pump_oe,
   output logic             pump_hi,
   output logic             cmp_ref_o,
   output logic             cmp_fb_pull,
   output logic             mon_o
);
   generate
      if (CNT_W < 2 || CNT_W > 24) begin : g_bad_width
         $error("phase_cmp_lock: CNT_W out of range");
      end
      if (LOCK_RUNS < 1 || LOCK_RUNS > 64) begin : g_bad_runs
         $error("phase_cmp_lock: LOCK_RUNS out of range");
      end
   endgenerate

   pd_flags_t flags;
   logic      cmp_done, restart_q, lock_q, pd_up, pd_dn;

   assign pd_up = flags.up;
   assign pd_dn = flags.dn;

   pcl_detector u_det (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fb_tick(fb_tick),
      .psave(psave), .flags(flags), .cmp_done(cmp_done), .restart_q(restart_q)
   );

   pcl_lockdet #(.CNT_W(CNT_W), .RUNS(LOCK_RUNS)) u_lock (
      .clk(clk), .rst_n(rst_n), .psave(psave), .active(pd_up | pd_dn),
      .cmp_done(cmp_done), .lock_max(lock_max), .unlock_min(unlock_min),
      .locked(lock_q)
   );

   pcl_outstage u_out (
      .flags(flags), .sense_pos(sense_pos), .pump_allow(pump_allow),
      .psave(psave), .mon_sel(mon_sel), .ref_tick(ref_tick), .fb_tick(fb_tick),
      .locked(lock_q), .pump_oe(pump_oe), .pump_hi(pump_hi),
      .cmp_ref_o(cmp_ref_o), .cmp_fb_pull(cmp_fb_pull), .mon_o(mon_o)
   );
endmodule

// File: rtl/pcl_checker.sv
module pcl_checker #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             psave,
   input logic             pump_allow,
   input logic             mon_sel,
   input logic             mon_o,
   input logic             pump_oe,
   input logic             up,
   input logic             dn,
   input logic             lock_q,
   input logic             restart_q,
   input logic             ref_tick,
   input logic             fb_tick,
   input logic [CNT_W-1:0] unlock_min
);
   logic [CNT_W-1:0] run_q;
   logic [CNT_W:0]   run_next;

   assign run_next = (&run_q) ? {1'b0, run_q} : {1'b0, run_q} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_q <= '0;
      else if (up || dn) run_q <= run_next[CNT_W-1:0];
      else               run_q <= '0;
   end

   // R3: the detector never holds both flags
   p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({up, dn}));

   // R9: the float override wins over any error
   p_float_override_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !pump_allow |-> !pump_oe);

   // R10: power-save floats the pump and shows lock
   p_psave_float_r10: assert property (@(posedge clk) disable iff (!rst_n)
      psave |-> !pump_oe);
   p_psave_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (psave && !mon_sel) |-> mon_o);

   // R7: a pulse that reaches the unlock width clears the lock flag
   p_unlock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((up || dn) && !psave && unlock_min != '0 && run_next >= {1'b0, unlock_min})
      |=> !lock_q);

   // R11: the first tick after power-save sets no flag
   p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (restart_q && !psave && (ref_tick || fb_tick)) |=> !(up || dn));
endmodule

bind phase_cmp_lock pcl_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .psave(psave), .pump_allow(pump_allow),
   .mon_sel(mon_sel), .mon_o(mon_o), .pump_oe(pump_oe), .up(pd_up), .dn(pd_dn),
   .lock_q(lock_q), .restart_q(restart_q), .ref_tick(ref_tick),
   .fb_tick(fb_tick), .unlock_min(unlock_min)
);

// File: tb/sim_phase_cmp_lock.sv
module sim_phase_cmp_lock;
   localparam int CW   = 4;
   localparam int RUNS = 3;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, ref_tick, fb_tick, sense_pos, pump_allow, psave, mon_sel;
   logic [CW-1:0] lock_max, unlock_min;
   logic pump_oe, pump_hi, cmp_ref_o, cmp_fb_pull, mon_o;

   int n_cmp = 0;
   int n_bad = 0;
   int m_lock = 0;
   int m_good = 0;

   phase_cmp_lock #(.CNT_W(CW), .LOCK_RUNS(RUNS)) u0 (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fb_tick(fb_tick),
      .sense_pos(sense_pos), .pump_allow(pump_allow), .psave(psave),
      .mon_sel(mon_sel), .lock_max(lock_max), .unlock_min(unlock_min),
      .pump_oe(pump_oe), .pump_hi(pump_hi), .cmp_ref_o(cmp_ref_o),
      .cmp_fb_pull(cmp_fb_pull), .mon_o(mon_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input logic r, input logic f);
      ref_tick = r;
      fb_tick  = f;
      @(negedge clk);
      ref_tick = 1'b0;
      fb_tick  = 1'b0;
   endtask

   // one comparison: leader tick in cycle 0, follower in cycle d
   task automatic pair(input int pol, input int ref_first, input int d);
      sense_pos = pol[0];
      for (int i = 0; i <= d + 1; i++) begin
         logic r, f;
         int   act, hi_e, cr_e, cp_e, width;
         string ptag, ltag;
         r = (ref_first != 0) ? (i == 0) : (i == d);
         f = (ref_first != 0) ? (i == d) : (i == 0);
         cyc(r, f);
         act  = (i < d) ? 1 : 0;
         hi_e = act & ((pol != 0) ? ref_first : (ref_first == 0 ? 1 : 0));
         cr_e = act & ((pol != 0) ? (ref_first == 0 ? 1 : 0) : ref_first);
         cp_e = act & ((pol != 0) ? ref_first : (ref_first == 0 ? 1 : 0));
         ptag = (d == 0) ? "R3 coincident" : ((pol != 0) ? "R1 pump" : "R2 pump");
         chk({ptag, " oe"}, int'(pump_oe), act);
         chk({ptag, " level"}, int'(pump_hi), hi_e);
         chk("R4 cmp_ref_o", int'(cmp_ref_o), cr_e);
         chk("R4 cmp_fb_pull", int'(cmp_fb_pull), cp_e);
         ltag = "R8 lock run";
         if (i >= 1 && i <= d && i >= int'(unlock_min)) begin
            if (i == int'(unlock_min)) ltag = "R7 unlock edge";
            m_lock = 0;
            m_good = 0;
         end else if (i == d) begin
            width = d;
            if (width <= int'(lock_max)) begin
               if (m_good < RUNS) m_good++;
               if (m_good >= RUNS) m_lock = 1;
            end else begin
               m_good = 0;
            end
         end
         chk({ltag, " R6 mon"}, int'(mon_o), m_lock);
      end
   endtask

   initial begin
      #(200000 * 4);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; ref_tick = 1'b0; fb_tick = 1'b0; sense_pos = 1'b1;
      pump_allow = 1'b1; psave = 1'b0; mon_sel = 1'b0;
      lock_max = 4'd1; unlock_min = 4'd2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12: reset state
      chk("R12 pump_oe", int'(pump_oe), 0);
      chk("R12 cmp_ref_o", int'(cmp_ref_o), 0);
      chk("R12 cmp_fb_pull", int'(cmp_fb_pull), 0);
      chk("R12 lock", int'(mon_o), 0);

      // R1..R4, R6..R8: sweep of spacing, order and polarity
      for (int pol = 0; pol < 2; pol++)
         for (int rf = 0; rf < 2; rf++)
            for (int d = 0; d <= 4; d++)
               pair(pol, rf, d);

      // R8: a middle-width comparison restarts the run
      unlock_min = 4'd4;
      pair(1, 1, 0); pair(1, 1, 3);
      pair(1, 1, 1); pair(1, 0, 1);
      chk("R8 not yet locked", int'(mon_o), 0);
      pair(1, 1, 0);
      chk("R8 relocked after three", int'(mon_o), 1);
      pair(1, 0, 2);
      pair(1, 0, 3);
      chk("R8 middle width keeps lock", int'(mon_o), 1);
      pair(0, 1, 4);
      chk("R7 unlock at width four", int'(mon_o), 0);
      unlock_min = 4'd2;

      // R5: monitor follows the selected tick stream
      mon_sel = 1'b1;
      for (int pol = 0; pol < 2; pol++)
         for (int c = 0; c < 4; c++) begin
            sense_pos = pol[0];
            ref_tick  = c[0];
            fb_tick   = c[1];
            #1;
            chk("R5 monitor", int'(mon_o), (pol != 0) ? c[0] : c[1]);
            @(negedge clk);
            ref_tick = 1'b0;
            fb_tick  = 1'b0;
         end
      cyc(1'b0, 1'b1);
      cyc(1'b1, 1'b1);
      mon_sel = 1'b0;

      // R10: power-save
      psave = 1'b1;
      sense_pos = 1'b1;
      #1;
      chk("R10 lock forced", int'(mon_o), 1);
      cyc(1'b1, 1'b0);
      chk("R10 pump floats", int'(pump_oe), 0);
      chk("R10 no flag", int'(cmp_fb_pull), 0);
      cyc(1'b0, 1'b1);
      chk("R10 pump floats fb", int'(pump_oe), 0);
      psave = 1'b0;
      @(negedge clk);
      chk("R10 lock held after exit", int'(mon_o), 1);

      // R11: restart absorbs the first tick
      cyc(1'b1, 1'b0);
      chk("R11 first tick absorbed", int'(pump_oe), 0);
      chk("R11 first tick no cmp", int'(cmp_fb_pull), 0);
      cyc(1'b0, 1'b1);
      chk("R11 next tick drives", int'(pump_oe), 1);
      chk("R11 next tick level", int'(pump_hi), 0);
      cyc(1'b1, 1'b0);
      chk("R11 cleared", int'(pump_oe), 0);
      chk("R10 lock kept", int'(mon_o), 1);

      // R9: float override
      pump_allow = 1'b0;
      cyc(1'b1, 1'b0);
      chk("R9 forced float", int'(pump_oe), 0);
      chk("R9 comparator still active", int'(cmp_fb_pull), 1);
      pump_allow = 1'b1;
      #1;
      chk("R9 drive resumes", int'(pump_oe), 1);
      chk("R9 level", int'(pump_hi), 1);
      @(negedge clk);
      cyc(1'b0, 1'b1);
      chk("R9 cleared", int'(pump_oe), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule